// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block resolves control transfer for a 32-bit load/store processor whose branches and jumps each carry one architectural delay slot. For every request it takes the address of the control-transfer instruction, an already-decoded transfer kind, the 16-bit immediate field, the 26-bit jump index field and the two source register values. One clock edge later it returns four things:

- whether the transfer is taken;
- the address fetch must continue from once the delay slot has issued;
- whether a return address is written back;
- if so, which register receives it and what value it holds.

The instruction in the delay slot always executes. A taken transfer never squashes it, and the unit never emits a kill signal. When nothing is taken, execution continues at the instruction after the delay slot, eight bytes past the transfer. Branches compare the two registers with each other, or compare rs with zero as a signed number. Pseudo-direct jumps keep the top four bits of the transfer's own address. Register jumps go to the value in rs. Linking forms save the transfer address plus eight.

The unit does not forward operands. It expects resolved register values from the surrounding pipeline.

Top module: `bj_next_pc`

## Requirements
- R1: Results are registered. A request accepted with `req_vld_i` high at a rising edge appears on the result ports after that edge, with `res_vld_o` high. Without a request, every result output is zero on the following cycle. A synchronous active-high `rst_i` clears all result outputs, even while a request is presented.
- R2: A taken conditional branch sends fetch to the transfer address plus 4, plus the 16-bit immediate sign-extended and shifted left by two. The sum wraps at 32 bits.
- R3: Kind 1 is taken when rs equals rt. Kind 2 is taken when rs differs from rt.
- R4: Kind 3 is taken when rs, read as signed, is at most zero. Kind 4 is taken when rs, read as signed, is greater than zero.
- R5: Kind 5 is the register-immediate branch group. Bit 16 of the jump index field (bit 0 of the rt field) selects the test. A value of 0 means taken when signed rs is below zero. A value of 1 means taken when signed rs is zero or above.
- R6: Kinds 6 and 7 are always taken. Their target is bits 31..28 of the transfer address, then the 26-bit index field, then two zero bits.
- R7: Kinds 8 and 9 are always taken, and their target is the full 32-bit value of rs.
- R8: Kind 7 asserts the link write with register index 31. Kind 9 asserts it with the register index found in immediate bits 15..11. Both link values equal the transfer address plus 8.
- R9: When a request is not taken, the next address is the transfer address plus 8. Every form except kinds 7 and 9 leaves the link write low, with link index and link value zero.
- R10: Kind 0 and the unused codes 10 to 15 are treated as non-control instructions: never taken and never linking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| req_vld_i | input | 1 | A request is presented this cycle |
| req_kind_i | input | 4 | Decoded transfer kind (codes per R3 to R10) |
| req_pc_i | input | 32 | Address of the control-transfer instruction |
| req_imm_i | input | 16 | Immediate field; bits 15..11 double as the rd index |
| req_jidx_i | input | 26 | Jump index field; bit 16 is the rt-field selector bit |
| req_rs_i | input | 32 | Value of source register rs |
| req_rt_i | input | 32 | Value of source register rt |
| res_vld_o | output | 1 | Result is valid |
| res_taken_o | output | 1 | Transfer is taken |
| res_pc_o | output | 32 | Address to fetch after the delay slot |
| res_link_we_o | output | 1 | Return address is to be written |
| res_link_idx_o | output | 5 | Destination register of the return address |
| res_link_val_o | output | 32 | Return address value |

## Verification
The hardest cases to reach are the ones where a single bit of rs decides the outcome. For zero comparisons that means rs at exactly zero, at the most negative value and at the most positive value. For the register-immediate group it means the selector bit sitting in the middle of the jump index field, with the remaining index bits set to unrelated noise. The directed stimulus pairs every zero-test kind with each of those three values, and sends kind 5 twice with identical rs while only bit 16 flips. Two address-arithmetic corners are reached the same way: a backward branch that wraps below address zero, and a jump whose source sits just under a 256 MB region boundary. A long stream of arbitrary kinds, including unused codes, is sent back to back. It checks that results never fall out of order and that a request always follows an idle cycle cleanly.

// File: rtl/bj_pkg.sv
package bj_pkg;

    parameter int ADDR_W    = 32;
    parameter int IMM_W     = 16;
    parameter int JIDX_W    = 26;
    parameter int REGIDX_W  = 5;
    parameter int KIND_W    = 4;

    typedef enum logic [KIND_W-1:0] {
        XK_NONE   = 4'd0,
        XK_BEQ    = 4'd1,
        XK_BNE    = 4'd2,
        XK_BLEZ   = 4'd3,
        XK_BGTZ   = 4'd4,
        XK_REGIMM = 4'd5,
        XK_J      = 4'd6,
        XK_JAL    = 4'd7,
        XK_JR     = 4'd8,
        XK_JALR   = 4'd9
    } xfer_kind_e;

endpackage

// File: rtl/bj_cond_eval.sv
module bj_cond_eval
    import bj_pkg::*;
#(
    parameter int W      = ADDR_W,
    parameter int KW     = KIND_W
) (
    input  logic [KW-1:0] kind_i,
    input  logic [W-1:0]  rs_i,
    input  logic [W-1:0]  rt_i,
    input  logic          regimm_sel_i,
    output logic          is_branch_o,
    output logic          is_jump_o,
    output logic          taken_o
);

    logic rs_neg;
    logic rs_zero;
    logic regs_eq;
    logic cond_hit;

    always_comb begin
        rs_neg  = rs_i[W-1];
        rs_zero = (rs_i == '0);
        regs_eq = (rs_i == rt_i);
    end

    always_comb begin
        is_branch_o = 1'b0;
        is_jump_o   = 1'b0;
        cond_hit    = 1'b0;
        case (kind_i)
            XK_BEQ: begin
                is_branch_o = 1'b1;
                cond_hit    = regs_eq;
            end
            XK_BNE: begin
                is_branch_o = 1'b1;
                cond_hit    = !regs_eq;
            end
            XK_BLEZ: begin
                is_branch_o = 1'b1;
                cond_hit    = rs_neg | rs_zero;
            end
            XK_BGTZ: begin
                is_branch_o = 1'b1;
                cond_hit    = !rs_neg && !rs_zero;
            end
            XK_REGIMM: begin
                is_branch_o = 1'b1;
                cond_hit    = regimm_sel_i ? !rs_neg : rs_neg;
            end
            XK_J, XK_JAL, XK_JR, XK_JALR: begin
                is_jump_o = 1'b1;
            end
            default: begin
                is_branch_o = 1'b0;
            end
        endcase
        taken_o = is_jump_o | (is_branch_o & cond_hit);
    end

endmodule

// File: rtl/bj_target_gen.sv
module bj_target_gen
    import bj_pkg::*;
#(
    parameter int W    = ADDR_W,
    parameter int IW   = IMM_W,
    parameter int JW   = JIDX_W,
    parameter int KW   = KIND_W
) (
    input  logic [KW-1:0] kind_i,
    input  logic [W-1:0]  pc_i,
    input  logic [IW-1:0] imm_i,
    input  logic [JW-1:0] jidx_i,
    input  logic [W-1:0]  rs_i,
    output logic [W-1:0]  taken_pc_o,
    output logic [W-1:0]  seq_pc_o
);

    localparam int EXT_W    = W - IW - 2;
    localparam int REGION_W = W - JW - 2;

    logic [W-1:0] pc_plus4;
    logic [W-1:0] br_off;
    logic [W-1:0] br_pc;
    logic [W-1:0] jmp_pc;

    always_comb begin
        pc_plus4 = pc_i + W'(4);
        seq_pc_o = pc_i + W'(8);
        br_off   = {{EXT_W{imm_i[IW-1]}}, imm_i, 2'b00};
        br_pc    = pc_plus4 + br_off;
        jmp_pc   = {pc_i[W-1 -: REGION_W], jidx_i, 2'b00};
    end

    always_comb begin
        case (kind_i)
            XK_J, XK_JAL:   taken_pc_o = jmp_pc;
            XK_JR, XK_JALR: taken_pc_o = rs_i;
            default:        taken_pc_o = br_pc;
        endcase
    end

endmodule

// File: rtl/bj_link_gen.sv
module bj_link_gen
    import bj_pkg::*;
#(
    parameter int W      = ADDR_W,
    parameter int RW     = REGIDX_W,
    parameter int KW     = KIND_W,
    parameter int LINK_R = 31
) (
    input  logic [KW-1:0] kind_i,
    input  logic [W-1:0]  seq_pc_i,
    input  logic [RW-1:0] rd_i,
    output logic          we_o,
    output logic [RW-1:0] idx_o,
    output logic [W-1:0]  val_o
);

    always_comb begin
        we_o  = 1'b0;
        idx_o = '0;
        val_o = '0;
        case (kind_i)
            XK_JAL: begin
                we_o  = 1'b1;
                idx_o = RW'(LINK_R);
                val_o = seq_pc_i;
            end
            XK_JALR: begin
                we_o  = 1'b1;
                idx_o = rd_i;
                val_o = seq_pc_i;
            end
            default: begin
                we_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bj_next_pc.sv
module bj_next_pc
    import bj_pkg::*;
#(
    parameter int W      = ADDR_W,
    parameter int IW     = IMM_W,
    parameter int JW     = JIDX_W,
    parameter int RW     = REGIDX_W,
    parameter int KW     = KIND_W,
    parameter int LINK_R = 31,
    parameter int SEL_B  = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_vld_i,
    input  logic [KW-1:0] req_kind_i,
    input  logic [W-1:0]  req_pc_i,
    input  logic [IW-1:0] req_imm_i,
    input  logic [JW-1:0] req_jidx_i,
    input  logic [W-1:0]  req_rs_i,
    input  logic [W-1:0]  req_rt_i,
    output logic          res_vld_o,
    output logic          res_taken_o,
    output logic [W-1:0]  res_pc_o,
    output logic          res_link_we_o,
    output logic [RW-1:0] res_link_idx_o,
    output logic [W-1:0]  res_link_val_o
);

    typedef struct packed {
        logic          vld;
        logic          taken;
        logic [W-1:0]  pc;
        logic          we;
        logic [RW-1:0] idx;
        logic [W-1:0]  val;
    } res_t;

    res_t st_d, st_q;

    logic          is_branch;
    logic          is_jump;
    logic          taken_c;
    logic [W-1:0]  taken_pc;
    logic [W-1:0]  seq_pc;
    logic          lnk_we;
    logic [RW-1:0] lnk_idx;
    logic [W-1:0]  lnk_val;

    bj_cond_eval #(.W(W), .KW(KW)) cond_i (
        .kind_i       (req_kind_i),
        .rs_i         (req_rs_i),
        .rt_i         (req_rt_i),
        .regimm_sel_i (req_jidx_i[SEL_B]),
        .is_branch_o  (is_branch),
        .is_jump_o    (is_jump),
        .taken_o      (taken_c)
    );

    bj_target_gen #(.W(W), .IW(IW), .JW(JW), .KW(KW)) tgt_i (
        .kind_i     (req_kind_i),
        .pc_i       (req_pc_i),
        .imm_i      (req_imm_i),
        .jidx_i     (req_jidx_i),
        .rs_i       (req_rs_i),
        .taken_pc_o (taken_pc),
        .seq_pc_o   (seq_pc)
    );

    bj_link_gen #(.W(W), .RW(RW), .KW(KW), .LINK_R(LINK_R)) lnk_i (
        .kind_i   (req_kind_i),
        .seq_pc_i (seq_pc),
        .rd_i     (req_imm_i[IW-1 -: RW]),
        .we_o     (lnk_we),
        .idx_o    (lnk_idx),
        .val_o    (lnk_val)
    );

    always_comb begin
        st_d = '0;
        if (req_vld_i) begin
            st_d.vld   = 1'b1;
            st_d.taken = taken_c;
            st_d.pc    = taken_c ? taken_pc : seq_pc;
            st_d.we    = lnk_we;
            st_d.idx   = lnk_idx;
            st_d.val   = lnk_val;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o      = st_q.vld;
    assign res_taken_o    = st_q.taken;
    assign res_pc_o       = st_q.pc;
    assign res_link_we_o  = st_q.we;
    assign res_link_idx_o = st_q.idx;
    assign res_link_val_o = st_q.val;

    logic unused_flags;
    assign unused_flags = is_branch ^ is_jump;

    a_r1_vld_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        req_vld_i |=> res_vld_o);

    a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_vld_i |=> (!res_vld_o && !res_taken_o && !res_link_we_o && res_pc_o == '0));

    a_r6_jump_region: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i && (req_kind_i == XK_J || req_kind_i == XK_JAL)) |=>
        (res_taken_o && res_pc_o[W-1 -: 4] == $past(req_pc_i[W-1 -: 4]) && res_pc_o[1:0] == 2'b00));

    a_r7_reg_target: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i && (req_kind_i == XK_JR || req_kind_i == XK_JALR)) |=>
        (res_taken_o && res_pc_o == $past(req_rs_i)));

    a_r8_jal_link: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i && req_kind_i == XK_JAL) |=>
        (res_link_we_o && res_link_idx_o == RW'(LINK_R) && res_link_val_o == $past(req_pc_i) + W'(8)));

    a_r9_fallthrough: assert property (@(posedge clk_i) disable iff (rst_i)
        req_vld_i |=> (res_taken_o || res_pc_o == $past(req_pc_i) + W'(8)));

    a_r10_none_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i && req_kind_i == XK_NONE) |=> (!res_taken_o && !res_link_we_o));

endmodule

// File: tb/bj_next_pc_tb_top.sv
module bj_next_pc_tb_top;
    import bj_pkg::*;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        req_vld_i = 1'b0;
    logic [3:0]  req_kind_i = '0;
    logic [31:0] req_pc_i = '0;
    logic [15:0] req_imm_i = '0;
    logic [25:0] req_jidx_i = '0;
    logic [31:0] req_rs_i = '0;
    logic [31:0] req_rt_i = '0;
    logic        res_vld_o;
    logic        res_taken_o;
    logic [31:0] res_pc_o;
    logic        res_link_we_o;
    logic [4:0]  res_link_idx_o;
    logic [31:0] res_link_val_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk_i = ~clk_i;

    bj_next_pc dut_i (
        .clk_i, .rst_i, .req_vld_i, .req_kind_i, .req_pc_i, .req_imm_i,
        .req_jidx_i, .req_rs_i, .req_rt_i, .res_vld_o, .res_taken_o,
        .res_pc_o, .res_link_we_o, .res_link_idx_o, .res_link_val_o
    );

    typedef struct {
        logic        taken;
        logic [31:0] pc;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t predict(logic [3:0] k, logic [31:0] pc, logic [15:0] imm,
                                     logic [25:0] jx, logic [31:0] rs, logic [31:0] rt,
                                     string tag);
        exp_t e;
        logic signed [31:0] srs;
        logic [31:0] boff;
        srs     = rs;
        boff    = 32'(signed'(imm)) * 4;
        e.taken = 1'b0;
        e.we    = 1'b0;
        e.idx   = '0;
        e.val   = '0;
        e.tag   = tag;
        e.pc    = pc + 32'd8;
        case (k)
            4'd1: if (rs == rt) begin e.taken = 1; e.pc = pc + 32'd4 + boff; end
            4'd2: if (rs != rt) begin e.taken = 1; e.pc = pc + 32'd4 + boff; end
            4'd3: if (srs <= 0) begin e.taken = 1; e.pc = pc + 32'd4 + boff; end
            4'd4: if (srs > 0)  begin e.taken = 1; e.pc = pc + 32'd4 + boff; end
            4'd5: if (jx[16] ? (srs >= 0) : (srs < 0)) begin
                      e.taken = 1; e.pc = pc + 32'd4 + boff;
                  end
            4'd6: begin e.taken = 1; e.pc = {pc[31:28], jx, 2'b00}; end
            4'd7: begin e.taken = 1; e.pc = {pc[31:28], jx, 2'b00};
                        e.we = 1; e.idx = 5'd31; e.val = pc + 32'd8; end
            4'd8: begin e.taken = 1; e.pc = rs; end
            4'd9: begin e.taken = 1; e.pc = rs;
                        e.we = 1; e.idx = imm[15:11]; e.val = pc + 32'd8; end
            default: e.taken = 1'b0;
        endcase
        return e;
    endfunction

    task automatic send(logic [3:0] k, logic [31:0] pc, logic [15:0] imm, logic [25:0] jx,
                        logic [31:0] rs, logic [31:0] rt, string tag);
        exp_t e;
        e = predict(k, pc, imm, jx, rs, rt, tag);
        @(negedge clk_i);
        req_vld_i  = 1'b1;
        req_kind_i = k;
        req_pc_i   = pc;
        req_imm_i  = imm;
        req_jidx_i = jx;
        req_rs_i   = rs;
        req_rt_i   = rt;
        sb_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            req_vld_i = 1'b0;
            req_kind_i = $urandom_range(15, 0);
            req_pc_i   = $urandom;
        end
    endtask

    always @(negedge clk_i) begin
        if (!rst_i && res_vld_o) begin
            if (sb_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R1 unexpected result: actual vld 1 expected vld 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, 32'(res_taken_o),    32'(e.taken), "taken");
                check(e.tag, res_pc_o,            e.pc,         "next pc");
                check(e.tag, 32'(res_link_we_o),  32'(e.we),    "link we");
                check(e.tag, 32'(res_link_idx_o), 32'(e.idx),   "link idx");
                check(e.tag, res_link_val_o,      e.val,        "link val");
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk_i);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates a presented request
        req_vld_i = 1'b1;
        req_kind_i = 4'd8;
        req_rs_i = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check("R1", 32'({res_vld_o, res_taken_o, res_link_we_o}), 32'd0, "reset flags");
        check("R1", res_pc_o, 32'd0, "reset pc");
        check("R1", res_link_val_o, 32'd0, "reset link");
        req_vld_i = 1'b0;
        rst_i = 1'b0;
        idle(2);
        check("R1", 32'(res_vld_o), 32'd0, "idle vld");

        // R3 equality branches, R2 forward/backward targets
        send(4'd1, 32'h0000_1000, 16'h0010, 26'h0, 32'd7, 32'd7, "R3 beq taken R2");
        send(4'd1, 32'h0000_1000, 16'h0010, 26'h0, 32'd7, 32'd8, "R3 beq not taken R9");
        send(4'd2, 32'h0000_2000, 16'hFFFE, 26'h0, 32'd1, 32'd2, "R3 bne taken R2 back");
        send(4'd2, 32'h0000_2000, 16'hFFFE, 26'h0, 32'd5, 32'd5, "R3 bne not taken");
        send(4'd1, 32'h0000_0004, 16'h8000, 26'h0, 32'd0, 32'd0, "R2 wrap below zero");
        // R4 signed zero tests at the edges
        send(4'd3, 32'h0040_0000, 16'h0003, 26'h0, 32'd0,         32'd0, "R4 blez zero");
        send(4'd3, 32'h0040_0000, 16'h0003, 26'h0, 32'h8000_0000, 32'd0, "R4 blez min");
        send(4'd3, 32'h0040_0000, 16'h0003, 26'h0, 32'h7FFF_FFFF, 32'd0, "R4 blez max");
        send(4'd4, 32'h0040_0000, 16'h0003, 26'h0, 32'd0,         32'd0, "R4 bgtz zero");
        send(4'd4, 32'h0040_0000, 16'h0003, 26'h0, 32'h8000_0000, 32'd0, "R4 bgtz min");
        send(4'd4, 32'h0040_0000, 16'h0003, 26'h0, 32'h7FFF_FFFF, 32'd0, "R4 bgtz max");
        // R5 selector bit 16 of the index field, other bits noisy
        send(4'd5, 32'h0050_0000, 16'h0020, 26'h3FE_FFFF & 26'h3FEFFFF, 32'h8000_0000, 32'd0, "R5 bltz neg");
        send(4'd5, 32'h0050_0000, 16'h0020, 26'h001_0000 | 26'h3E0_FFFF, 32'h8000_0000, 32'd0, "R5 bgez neg");
        send(4'd5, 32'h0050_0000, 16'h0020, 26'h2A0_5555, 32'd0, 32'd0, "R5 bltz zero");
        send(4'd5, 32'h0050_0000, 16'h0020, 26'h2A1_5555, 32'd0, 32'd0, "R5 bgez zero");
        idle(1);
        check("R1", 32'(res_vld_o), 32'd1, "last of burst");
        // R6 pseudo-direct jumps at a region edge, R8 link
        send(4'd6, 32'h1FFF_FFFC, 16'h0, 26'h3FF_FFFF, 32'd0, 32'd0, "R6 j region edge");
        send(4'd7, 32'hF000_0100, 16'h0, 26'h012_3456, 32'd0, 32'd0, "R6 R8 jal link 31");
        // R7 register jumps, R8 rd from imm[15:11]
        send(4'd8, 32'h0000_3000, 16'hFFFF, 26'h0, 32'h1234_5679, 32'd0, "R7 jr");
        send(4'd9, 32'hFFFF_FFFC, 16'hA800, 26'h0, 32'h0000_0400, 32'd0, "R7 R8 jalr wrap");
        // R10 non-control and unused codes
        send(4'd0,  32'h0000_4000, 16'h1234, 26'h3FF_FFFF, 32'd1, 32'd1, "R10 none");
        send(4'd10, 32'h0000_4000, 16'h1234, 26'h3FF_FFFF, 32'd1, 32'd1, "R10 code 10");
        send(4'd15, 32'h0000_4000, 16'hF800, 26'h3FF_FFFF, 32'd1, 32'd1, "R10 code 15 R9");
        idle(3);
        check("R1", 32'(res_vld_o), 32'd0, "idle after burst");
        check("R1", res_pc_o, 32'd0, "idle pc zero");

        // back-to-back mixed stream with occasional gaps
        for (int i = 0; i < 300; i++) begin
            logic [31:0] rs;
            logic [31:0] rt;
            rs = $urandom;
            rt = ($urandom_range(3, 0) == 0) ? rs : $urandom;
            if ($urandom_range(7, 0) == 0) rs = 32'd0;
            send(4'($urandom_range(15, 0)), $urandom, 16'($urandom), 26'($urandom),
                 rs, rt, "R10 mixed stream R2 R3 R4 R5 R6 R7 R8 R9");
            if ($urandom_range(9, 0) == 0) idle(1);
        end
        idle(3);
        check("R1", 32'(sb_q.size()), 32'd0, "drained scoreboard");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule